// File: doc/BRIEF.md
# Dual-Bank General Register File

This block holds the sixteen general-purpose data registers of a processor core. Logical registers 0 to 7 have two physical copies, one per bank. Logical registers 8 to 15 have a single copy. Two status inputs pick the copy that the normal ports reach: a privilege flag and a bank flag. In user mode the low bank is always used. In privileged mode the bank flag picks the bank. The block registers both status inputs, so a bank change reaches the access ports one cycle after the inputs change.

The normal ports are two synchronous read ports and one write port, all addressed by logical register number. A separate side port reads or writes the low eight registers of the bank that is not selected. Privileged code uses it to reach the hidden copies. A side-port access made in user mode is dropped, and a one-cycle illegal-access flag is raised. All read data are registered. A read and a write to the same physical entry in the same cycle return the value held before the write.

Top module: `bankreg_file`

## Requirements
- R1: A synchronous reset drives `rd_a_data`, `rd_b_data`, `alt_rdata` and `alt_illegal` to zero on the cycle after reset is sampled.
- R2: In privileged mode (`priv_mode`=1), logical registers 0..7 map to bank 0 when `bank_sel`=0 and to bank 1 when `bank_sel`=1.
- R3: In user mode (`priv_mode`=0), logical registers 0..7 map to bank 0 whatever the value of `bank_sel`.
- R4: Logical registers 8..15 are one set, reached identically in every mode and bank state.
- R5: Each read port returns the register addressed at a clock edge on its data output right after that edge, and each port works independently of the other.
- R6: When the write port and a read port address the same physical register at the same edge, the read returns the value held before the write, and the new value is visible from the next access.
- R7: In privileged mode, the side port (`alt_en`=1, with `alt_we` choosing a write) reaches register `alt_addr` (0..7) of the bank not currently selected. Read data appear on `alt_rdata` after the edge, and the flag `alt_illegal` stays 0.
- R8: A side-port access made in user mode writes nothing and leaves `alt_rdata` unchanged. It sets `alt_illegal` to 1 for exactly the one cycle after the access.
- R9: A change on `priv_mode` or `bank_sel` first affects accesses presented at the clock edge after the one that samples the change. Accesses at the sampling edge still use the previous mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode | input | 1 | 1 = privileged mode, 0 = user mode |
| bank_sel | input | 1 | Bank choice for logical registers 0..7 in privileged mode |
| rd_a_addr | input | 4 | Logical register for read port A |
| rd_a_data | output | 32 | Registered data of read port A |
| rd_b_addr | input | 4 | Logical register for read port B |
| rd_b_data | output | 32 | Registered data of read port B |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | 4 | Logical register written |
| wr_data | input | 32 | Write data |
| alt_en | input | 1 | Side-port access request |
| alt_we | input | 1 | Side-port access is a write |
| alt_addr | input | 3 | Register 0..7 of the non-selected bank |
| alt_wdata | input | 32 | Side-port write data |
| alt_rdata | output | 32 | Registered side-port read data |
| alt_illegal | output | 1 | One-cycle flag for a side-port access refused in user mode |

## Verification
The bench uses the default sizes: 32-bit data, sixteen logical registers and eight banked ones. That gives 24 physical entries, few enough to write and read back every logical register in all four mode and bank combinations. The sweep covers every mapping path, including the case where user mode ignores the bank flag. Both read ports are checked on every register. The small size also lets the bench reach every hidden low-bank entry through the side port, and then check it through the normal ports after a bank change. A further check places an access in the exact cycle in which the bank input changes.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  typedef enum logic {
    BANK_LO = 1'b0,
    BANK_HI = 1'b1
  } bank_e;
endpackage

// File: rtl/bankreg_status.sv
// Registers the mode and bank inputs; the mapping follows one cycle later.
module bankreg_status
  import bankreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  priv_mode,
  input  logic  bank_sel,
  output logic  mode_q,
  output bank_e cur_bank,
  output bank_e hid_bank
);
  logic bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b1;
      bank_q <= 1'b1;
    end else begin
      mode_q <= priv_mode;
      bank_q <= bank_sel;
    end
  end

  always_comb begin
    cur_bank = (mode_q && bank_q) ? BANK_HI : BANK_LO;
    hid_bank = (cur_bank == BANK_HI) ? BANK_LO : BANK_HI;
  end
endmodule

// File: rtl/bankreg_mapper.sv
// Logical register number to physical entry index.
// Layout: [0, BANKED) bank 0, [BANKED, 2*BANKED) bank 1, then the shared set.
module bankreg_mapper
  import bankreg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int BANKED   = 8,
  localparam int AW      = $clog2(NUM_REGS),
  localparam int PHYS    = NUM_REGS + BANKED,
  localparam int PAW     = $clog2(PHYS)
) (
  input  logic [AW-1:0]  lreg,
  input  bank_e          bank,
  output logic [PAW-1:0] preg
);
  localparam logic [PAW-1:0] OFFS = PAW'(BANKED);
  logic [PAW-1:0] lwide;

  always_comb begin
    lwide = PAW'(lreg);
    if (lwide < OFFS) begin
      preg = (bank == BANK_HI) ? lwide + OFFS : lwide;
    end else begin
      preg = lwide + OFFS;
    end
  end
endmodule

// File: rtl/bankreg_storage.sv
// Physical entries with two write ports and three registered read-first reads.
module bankreg_storage #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 24,
  localparam int PAW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_main,
  input  logic [PAW-1:0]    wa_main,
  input  logic [DATA_W-1:0] wd_main,
  input  logic              we_side,
  input  logic [PAW-1:0]    wa_side,
  input  logic [DATA_W-1:0] wd_side,
  input  logic [PAW-1:0]    ra_a,
  input  logic [PAW-1:0]    ra_b,
  input  logic              re_side,
  input  logic [PAW-1:0]    ra_side,
  output logic [DATA_W-1:0] rq_a,
  output logic [DATA_W-1:0] rq_b,
  output logic [DATA_W-1:0] rq_side
);
  logic [DATA_W-1:0] mem [DEPTH];

  // The two write ports never address the same entry: the side port reaches
  // only the hidden bank, the main port only the visible one or shared set.
  always_ff @(posedge clk) begin
    if (we_main) mem[wa_main] <= wd_main;
    if (we_side) mem[wa_side] <= wd_side;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_a    <= '0;
      rq_b    <= '0;
      rq_side <= '0;
    end else begin
      rq_a <= mem[ra_a];
      rq_b <= mem[ra_b];
      if (re_side) rq_side <= mem[ra_side];
    end
  end
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int BANKED   = 8,
  localparam int AW      = $clog2(NUM_REGS),
  localparam int BAW     = $clog2(BANKED),
  localparam int PHYS    = NUM_REGS + BANKED,
  localparam int PAW     = $clog2(PHYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              priv_mode,
  input  logic              bank_sel,
  input  logic [AW-1:0]     rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [AW-1:0]     rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              alt_en,
  input  logic              alt_we,
  input  logic [BAW-1:0]    alt_addr,
  input  logic [DATA_W-1:0] alt_wdata,
  output logic [DATA_W-1:0] alt_rdata,
  output logic              alt_illegal
);
  logic           mode_q;
  bank_e          cur_bank;
  bank_e          hid_bank;
  logic [PAW-1:0] pa_a, pa_b, pa_w, pa_alt;
  logic [AW-1:0]  alt_lreg;
  logic           alt_ok;
  logic           illegal_q;

  bankreg_status u_status (
    .clk      (clk),
    .rst      (rst),
    .priv_mode(priv_mode),
    .bank_sel (bank_sel),
    .mode_q   (mode_q),
    .cur_bank (cur_bank),
    .hid_bank (hid_bank)
  );

  bankreg_mapper #(.NUM_REGS(NUM_REGS), .BANKED(BANKED)) u_map_a (
    .lreg(rd_a_addr), .bank(cur_bank), .preg(pa_a)
  );
  bankreg_mapper #(.NUM_REGS(NUM_REGS), .BANKED(BANKED)) u_map_b (
    .lreg(rd_b_addr), .bank(cur_bank), .preg(pa_b)
  );
  bankreg_mapper #(.NUM_REGS(NUM_REGS), .BANKED(BANKED)) u_map_w (
    .lreg(wr_addr), .bank(cur_bank), .preg(pa_w)
  );

  assign alt_lreg = AW'(alt_addr);
  bankreg_mapper #(.NUM_REGS(NUM_REGS), .BANKED(BANKED)) u_map_alt (
    .lreg(alt_lreg), .bank(hid_bank), .preg(pa_alt)
  );

  assign alt_ok = alt_en && mode_q;

  bankreg_storage #(.DATA_W(DATA_W), .DEPTH(PHYS)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we_main(wr_en),
    .wa_main(pa_w),
    .wd_main(wr_data),
    .we_side(alt_ok && alt_we),
    .wa_side(pa_alt),
    .wd_side(alt_wdata),
    .ra_a   (pa_a),
    .ra_b   (pa_b),
    .re_side(alt_ok),
    .ra_side(pa_alt),
    .rq_a   (rd_a_data),
    .rq_b   (rd_b_data),
    .rq_side(alt_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) illegal_q <= 1'b0;
    else     illegal_q <= alt_en && !mode_q;
  end
  assign alt_illegal = illegal_q;
endmodule

// File: rtl/bankreg_file_chk.sv
module bankreg_file_chk #(
  parameter int DATA_W = 32,
  parameter int PAW    = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              priv_mode,
  input logic              bank_sel,
  input logic              wr_en,
  input logic              alt_en,
  input logic              alt_we,
  input logic              mode_q,
  input logic              cur_bank,
  input logic [PAW-1:0]    pa_w,
  input logic [PAW-1:0]    pa_alt,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [DATA_W-1:0] rd_b_data,
  input logic [DATA_W-1:0] alt_rdata,
  input logic              alt_illegal
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (rd_a_data == '0 && rd_b_data == '0 && alt_rdata == '0 && !alt_illegal));

  // R8
  a_r8_illegal_pulse: assert property (@(posedge clk) disable iff (rst)
    (alt_en && !mode_q) |=> alt_illegal);

  // R7, R8
  a_r7_no_false_flag: assert property (@(posedge clk) disable iff (rst)
    !(alt_en && !mode_q) |=> !alt_illegal);

  // R8
  a_r8_alt_hold: assert property (@(posedge clk) disable iff (rst)
    (alt_en && !mode_q) |=> $stable(alt_rdata));

  // R9, R3
  a_r9_bank_lag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cur_bank == $past(priv_mode && bank_sel)));

  // R7
  a_r7_no_collision: assert property (@(posedge clk) disable iff (rst)
    (wr_en && alt_en && alt_we && mode_q) |-> (pa_w != pa_alt));
endmodule

bind bankreg_file bankreg_file_chk #(.DATA_W(DATA_W), .PAW(PAW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .priv_mode  (priv_mode),
  .bank_sel   (bank_sel),
  .wr_en      (wr_en),
  .alt_en     (alt_en),
  .alt_we     (alt_we),
  .mode_q     (mode_q),
  .cur_bank   (cur_bank),
  .pa_w       (pa_w),
  .pa_alt     (pa_alt),
  .rd_a_data  (rd_a_data),
  .rd_b_data  (rd_b_data),
  .alt_rdata  (alt_rdata),
  .alt_illegal(alt_illegal)
);

// File: tb/test_bankreg_file.sv
module test_bankreg_file;
  localparam int CLK_PERIOD = 10;
  localparam int NREG  = 16;
  localparam int NBANK = 8;
  localparam int NPHYS = NREG + NBANK;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        priv_mode = 1'b1, bank_sel = 1'b1;
  logic [3:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, alt_wdata = '0, alt_rdata;
  logic        wr_en = 1'b0, alt_en = 1'b0, alt_we = 1'b0, alt_illegal;
  logic [2:0]  alt_addr = '0;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] model [NPHYS];
  bit cm = 1'b1, cb = 1'b1;

  bankreg_file i_bankreg_file (
    .clk(clk), .rst(rst), .priv_mode(priv_mode), .bank_sel(bank_sel),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .alt_en(alt_en), .alt_we(alt_we), .alt_addr(alt_addr),
    .alt_wdata(alt_wdata), .alt_rdata(alt_rdata), .alt_illegal(alt_illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Physical index per requirements R2, R3, R4.
  function automatic int pmap(bit m, bit b, int r);
    if (r < NBANK) return (m && b) ? r + NBANK : r;
    return r + NBANK;
  endfunction
  // Hidden-bank index per R7.
  function automatic int amap(bit m, bit b, int i);
    return (m && b) ? i : i + NBANK;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_status(bit m, bit b);
    priv_mode = m; bank_sel = b;
    tick();
    cm = m; cb = b;
  endtask

  task automatic wr(int r, logic [31:0] v);
    wr_en = 1'b1; wr_addr = 4'(r); wr_data = v;
    tick();
    wr_en = 1'b0;
    model[pmap(cm, cb, r)] = v;
  endtask

  task automatic rd2(string req, int ra, int rb);
    rd_a_addr = 4'(ra); rd_b_addr = 4'(rb);
    tick();
    chk(req, rd_a_data, model[pmap(cm, cb, ra)]);
    chk(req, rd_b_data, model[pmap(cm, cb, rb)]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    // R1: outputs cleared by reset
    chk("R1 rd_a", rd_a_data, 32'h0);
    chk("R1 rd_b", rd_b_data, 32'h0);
    chk("R1 alt_rdata", alt_rdata, 32'h0);
    chk("R1 alt_illegal", {31'h0, alt_illegal}, 32'h0);
    rst = 1'b0;
    tick();

    // R2 R3 R4: write every logical register in every mode/bank state
    for (int st = 0; st < 4; st++) begin
      set_status(st[1], st[0]);
      for (int r = 0; r < NREG; r++)
        wr(r, 32'hC0DE_0000 | (st << 8) | r);
    end
    // R2 R3 R4 R5: read back through both ports in every state
    for (int st = 0; st < 4; st++) begin
      set_status(st[1], st[0]);
      for (int r = 0; r < NREG; r++)
        rd2(st[1] ? "R2 R4 R5 priv sweep" : "R3 R4 R5 user sweep", r, NREG - 1 - r);
    end

    // R6: read-during-write returns old value, new value afterwards
    set_status(1'b1, 1'b1);
    for (int r = 2; r < NREG; r += 6) begin
      logic [31:0] old_v;
      old_v = model[pmap(cm, cb, r)];
      wr_en = 1'b1; wr_addr = 4'(r); wr_data = 32'hBEEF_0000 | r;
      rd_a_addr = 4'(r);
      tick();
      wr_en = 1'b0;
      chk("R6 old value", rd_a_data, old_v);
      model[pmap(cm, cb, r)] = 32'hBEEF_0000 | r;
      tick();
      chk("R6 new value", rd_a_data, model[pmap(cm, cb, r)]);
    end

    // R7: side-port writes to hidden bank 0 while bank 1 is selected
    for (int i = 0; i < NBANK; i++) begin
      alt_en = 1'b1; alt_we = 1'b1; alt_addr = 3'(i); alt_wdata = 32'h5A00_0000 | i;
      tick();
      chk("R7 no flag on write", {31'h0, alt_illegal}, 32'h0);
      model[amap(cm, cb, i)] = 32'h5A00_0000 | i;
    end
    alt_we = 1'b0;
    for (int i = 0; i < NBANK; i++) begin
      alt_addr = 3'(i);
      tick();
      chk("R7 side read", alt_rdata, model[amap(cm, cb, i)]);
    end
    alt_en = 1'b0;
    // R2 R7: after switching to bank 0 the side-written values are visible
    set_status(1'b1, 1'b0);
    for (int i = 0; i < NBANK; i++) rd2("R7 visible after switch", i, i + NBANK);

    // R8: side access in user mode is refused
    set_status(1'b0, 1'b1);
    begin
      logic [31:0] held;
      held = alt_rdata;
      alt_en = 1'b1; alt_we = 1'b1; alt_addr = 3'd3; alt_wdata = 32'hDEAD_DEAD;
      tick();
      alt_en = 1'b0; alt_we = 1'b0;
      chk("R8 flag set", {31'h0, alt_illegal}, 32'h1);
      chk("R8 alt_rdata held", alt_rdata, held);
      tick();
      chk("R8 flag one cycle", {31'h0, alt_illegal}, 32'h0);
    end
    // R8: neither bank's register 3 was changed
    rd2("R8 bank0 unchanged", 3, 11);
    set_status(1'b1, 1'b0);
    alt_en = 1'b1; alt_addr = 3'd3;
    tick();
    alt_en = 1'b0;
    chk("R8 bank1 unchanged", alt_rdata, model[amap(cm, cb, 3)]);

    // R9: a read at the edge that samples a bank change still uses the old bank
    set_status(1'b1, 1'b1);
    begin
      logic [31:0] v_hi, v_lo;
      v_hi = model[pmap(1'b1, 1'b1, 5)];
      v_lo = model[pmap(1'b1, 1'b0, 5)];
      bank_sel = 1'b0; rd_a_addr = 4'd5;
      tick();
      chk("R9 old bank at change edge", rd_a_data, v_hi);
      tick();
      chk("R9 new bank next edge", rd_a_data, v_lo);
      cb = 1'b0;
      // mode change to user: same lag
      priv_mode = 1'b0; bank_sel = 1'b1;
      tick();
      chk("R9 mode lag", rd_a_data, v_lo);
      cm = 1'b0; cb = 1'b1;
      tick();
      chk("R3 user bank0", rd_a_data, v_lo);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule